// File: doc/BRIEF.md
# Pin Wake Condition Detector

This block watches a set of external input pins while the chip sits in a low-power freeze state and raises a wake request when the configured condition is met. Each pin carries a two-bit mode. A pin can stay out of the wake logic, wake on any change from the value it had when the freeze began, or belong to a signature group that wakes on a high or on a low level. A freeze begins on a one-cycle entry strobe. At that edge the block records the synchronized level of every pin. It then evaluates the wake rule on every cycle until the rule holds.

The wake rule has two terms joined by OR. The first is the OR of all change detectors. The second is the AND of every signature pin matching its level, and this term is false when no pin belongs to the signature. The signature term depends on level, not on edges, so a signature that still matches when the chip freezes again causes an immediate wake. While frozen, each pin outside the wake logic is driven with a park control that either holds its last value or floats it. Pins built without input capability never join the wake logic, whatever their mode.

Top module: `pin_wake_detect`

## Requirements
- R1: After reset, wake_o, frozen_o, hold_o and hiz_o are all zero.
- R2: A high freeze_enter_i at a clock edge while not frozen sets frozen_o from the next cycle. At that edge the synchronized pin levels are recorded as the reference.
- R3: A pin in mode 2'b01 requests wake when its synchronized level differs from its recorded reference, in either direction.
- R4: The change detections of several mode-2'b01 pins are ORed, so a change on any one of them is enough.
- R5: Mode 2'b10 pins must be high and mode 2'b11 pins must be low. A signature wake occurs only when every such pin matches its level at the same time.
- R6: When no pin is in mode 2'b10 or 2'b11 and no change is seen, no wake occurs and frozen_o stays high.
- R7: wake_o is a pulse of exactly one cycle. frozen_o is low in the same cycle that wake_o is high.
- R8: If the signature still matches when a new freeze begins, wake_o rises in the cycle after frozen_o rises.
- R9: Pin activity causes no wake while not frozen. A freeze_enter_i strobe while frozen neither wakes the block nor ends the freeze.
- R10: Pins in mode 2'b00 are ignored. A pin whose bit in the CAPABLE parameter is 0 is ignored in every mode and is treated as mode 2'b00.
- R11: While frozen, each pin treated as mode 2'b00 drives hold_o high if its keep_i bit is 1, and drives hiz_o high otherwise. Every other bit of hold_o and hiz_o is low, and all bits are low when not frozen.
- R12: With the default two synchronizer stages, a pin change applied before clock edge k produces wake_o after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | PINS | Raw asynchronous pin levels |
| mode_i | input | 2*PINS | Per-pin mode, pin k at bits [2k+1:2k]: 00 off, 01 change, 10 high, 11 low |
| keep_i | input | PINS | Per-pin park choice for off pins: 1 hold, 0 float |
| freeze_enter_i | input | 1 | One-cycle strobe that starts a freeze |
| wake_o | output | 1 | One-cycle wake request |
| frozen_o | output | 1 | High while the freeze is in force |
| hold_o | output | PINS | Per-pin hold-last-value control |
| hiz_o | output | PINS | Per-pin float control |

## Verification
The change term and the signature term can both become true in the same cycle. To provoke this, the bench toggles a change pin and completes the last missing signature level on the same negative edge. Both events then pass through the synchronizers together. The bench expects a single wake pulse at the usual three-edge latency, and it counts pulses over the following cycles to confirm that no second pulse follows, even though the signature still matches after the exit. A behavioural model built on queues also predicts every output on every cycle, so a doubled or missing pulse is caught wherever it occurs.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
   typedef enum logic [1:0] {
      WK_OFF  = 2'b00,
      WK_EDGE = 2'b01,
      WK_HIGH = 2'b10,
      WK_LOW  = 2'b11
   } wake_mode_e;

   typedef struct packed {
      logic keep;
      logic hiz;
   } pad_park_t;
endpackage

// File: rtl/pwd_sync.sv
module pwd_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/pwd_pin_cell.sv
module pwd_pin_cell
   import pwd_pkg::*;
#(
   parameter bit CAPABLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       keep_i,
   input  logic       pin_s_i,
   input  logic       frozen_i,
   input  logic       take_snap_i,
   input  logic       clear_snap_i,
   output logic       chg_hit_o,
   output logic       sig_member_o,
   output logic       sig_ok_o,
   output pad_park_t  park_o
);
   wake_mode_e eff;
   logic       snap_q;

   always_comb eff = CAPABLE ? wake_mode_e'(mode_i) : WK_OFF;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            snap_q <= 1'b0;
      else if (clear_snap_i) snap_q <= 1'b0;
      else if (take_snap_i)  snap_q <= pin_s_i;
   end

   always_comb begin
      chg_hit_o    = (eff == WK_EDGE) && (pin_s_i != snap_q);
      sig_member_o = (eff == WK_HIGH) || (eff == WK_LOW);
      sig_ok_o     = (eff == WK_HIGH) ? pin_s_i : !pin_s_i;
      park_o.keep  = frozen_i && (eff == WK_OFF) && keep_i;
      park_o.hiz   = frozen_i && (eff == WK_OFF) && !keep_i;
   end

   // R11
   park_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(park_o.keep && park_o.hiz));

   // R2
   snap_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_i && !clear_snap_i) |=> $stable(snap_q));
endmodule

// File: rtl/pwd_combine.sv
module pwd_combine #(
   parameter int N = 8
) (
   input  logic [N-1:0] chg_hit_i,
   input  logic [N-1:0] sig_member_i,
   input  logic [N-1:0] sig_ok_i,
   output logic         wake_cond_o
);
   logic any_chg, any_sig, all_ok;

   always_comb begin
      any_chg     = |chg_hit_i;
      any_sig     = |sig_member_i;
      all_ok      = &(sig_ok_i | ~sig_member_i);
      wake_cond_o = any_chg || (any_sig && all_ok);
   end
endmodule

// File: rtl/pin_wake_detect.sv
module pin_wake_detect
   import pwd_pkg::*;
#(
   parameter int              PINS        = 8,
   parameter int              SYNC_STAGES = 2,
   parameter logic [PINS-1:0] CAPABLE     = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PINS-1:0]   pins_i,
   input  logic [2*PINS-1:0] mode_i,
   input  logic [PINS-1:0]   keep_i,
   input  logic              freeze_enter_i,
   output logic              wake_o,
   output logic              frozen_o,
   output logic [PINS-1:0]   hold_o,
   output logic [PINS-1:0]   hiz_o
);
   localparam int MODE_W = 2 * PINS;

   if (PINS < 1) begin : g_bad_pins
      $error("PINS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ($bits(mode_i) != MODE_W) begin : g_bad_mode
      $error("mode width mismatch");
   end

   logic [PINS-1:0] pin_s, chg_hit, sig_member, sig_ok;
   pad_park_t       park [PINS];
   logic            wake_cond, frozen_q, wake_q, take_snap, clear_snap;

   pwd_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(pin_s)
   );

   assign take_snap  = freeze_enter_i && !frozen_q;
   assign clear_snap = frozen_q && wake_cond;

   for (genvar k = 0; k < PINS; k++) begin : g_pin
      pwd_pin_cell #(.CAPABLE(CAPABLE[k])) u_cell (
         .clk          (clk),
         .rst_n        (rst_n),
         .mode_i       (mode_i[2*k +: 2]),
         .keep_i       (keep_i[k]),
         .pin_s_i      (pin_s[k]),
         .frozen_i     (frozen_q),
         .take_snap_i  (take_snap),
         .clear_snap_i (clear_snap),
         .chg_hit_o    (chg_hit[k]),
         .sig_member_o (sig_member[k]),
         .sig_ok_o     (sig_ok[k]),
         .park_o       (park[k])
      );
      assign hold_o[k] = park[k].keep;
      assign hiz_o[k]  = park[k].hiz;
   end

   pwd_combine #(.N(PINS)) u_comb (
      .chg_hit_i    (chg_hit),
      .sig_member_i (sig_member),
      .sig_ok_i     (sig_ok),
      .wake_cond_o  (wake_cond)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frozen_q <= 1'b0;
         wake_q   <= 1'b0;
      end else begin
         wake_q <= frozen_q && wake_cond;
         if (frozen_q && wake_cond) frozen_q <= 1'b0;
         else if (take_snap)        frozen_q <= 1'b1;
      end
   end

   assign wake_o   = wake_q;
   assign frozen_o = frozen_q;

   // R7
   wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |=> !wake_q);

   // R7
   wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |-> !frozen_q);

   // R9
   wake_needs_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frozen_q |=> !wake_q);

   // R2
   freeze_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frozen_q) |-> $past(freeze_enter_i));

   // R11
   park_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frozen_q |-> (hold_o == '0 && hiz_o == '0));
endmodule

// File: tb/tb_pin_wake_detect.sv
`timescale 1ns/1ps
module tb_pin_wake_detect;
   localparam int              N    = 6;
   localparam int              SYNC = 2;
   localparam logic [N-1:0]    CAP  = 6'b101111;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   pins = '0;
   logic [2*N-1:0] mode = '0;
   logic [N-1:0]   keep = '0;
   logic           enter = 1'b0;
   logic           wake, frozen;
   logic [N-1:0]   hold, hiz;

   int checks = 0;
   int errors = 0;
   int wake_cnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pin_wake_detect #(.PINS(N), .SYNC_STAGES(SYNC), .CAPABLE(CAP)) dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .mode_i(mode), .keep_i(keep),
      .freeze_enter_i(enter), .wake_o(wake), .frozen_o(frozen),
      .hold_o(hold), .hiz_o(hiz)
   );

   // behavioural reference model
   logic [N-1:0] mq[$];
   logic [N-1:0] m_snap;
   logic         m_frozen, m_wake;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq = {};
         for (int i = 0; i < SYNC; i++) mq.push_back('0);
         m_snap = '0; m_frozen = 0; m_wake = 0;
      end else begin
         logic [N-1:0] cur;
         bit chg, anysig, allok, w;
         cur = mq.pop_front();
         mq.push_back(pins);
         chg = 0; anysig = 0; allok = 1;
         for (int k = 0; k < N; k++) begin
            int md;
            md = CAP[k] ? int'(mode[2*k +: 2]) : 0;
            if (md == 1 && cur[k] != m_snap[k]) chg = 1;
            if (md == 2) begin anysig = 1; if (!cur[k]) allok = 0; end
            if (md == 3) begin anysig = 1; if (cur[k]) allok = 0; end
         end
         w = m_frozen && (chg || (anysig && allok));
         m_wake = w;
         if (w) begin m_frozen = 0; m_snap = '0; end
         else if (!m_frozen && enter) begin m_frozen = 1; m_snap = cur; end
      end
   end

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         logic [N-1:0] eh, ez;
         for (int k = 0; k < N; k++) begin
            bit off;
            off = !CAP[k] || mode[2*k +: 2] == 2'b00;
            eh[k] = m_frozen && off && keep[k];
            ez[k] = m_frozen && off && !keep[k];
         end
         if (wake) wake_cnt++;
         checks++;
         if (wake !== m_wake || frozen !== m_frozen || hold !== eh || hiz !== ez) begin
            errors++;
            $display("FAIL model R3 R5 R7 R11: wake=%b frozen=%b hold=%b hiz=%b exp %b %b %b %b",
                     wake, frozen, hold, hiz, m_wake, m_frozen, eh, ez);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_mode(input int p, input logic [1:0] m);
      mode[2*p +: 2] = m;
   endtask

   task automatic pulse_enter();
      enter = 1'b1;
      @(negedge clk);
      enter = 1'b0;
   endtask

   task automatic wait_wake(input int maxc, output int lat);
      lat = -1;
      for (int i = 1; i <= maxc; i++) begin
         @(negedge clk);
         if (wake) begin lat = i; break; end
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int lat, base;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1
      chk(wake == 0 && frozen == 0 && hold == 0 && hiz == 0, "R1", {wake, frozen}, 0);

      // R9 activity with no freeze
      set_mode(0, 2'b01); set_mode(1, 2'b10);
      base = wake_cnt;
      pins[0] = 1; pins[1] = 1;
      cyc(6);
      chk(wake_cnt == base && frozen == 0, "R9", wake_cnt - base, 0);

      // R2 / R11 freeze entry and park outputs
      mode = '0; set_mode(0, 2'b01);
      keep = 6'b000100;
      cyc(1);
      pulse_enter();
      chk(frozen == 1, "R2", frozen, 1);
      chk(hold == 6'b000100, "R11", hold, 6'b000100);
      chk(hiz == 6'b111010, "R11", hiz, 6'b111010);

      // R9 second entry strobe while frozen
      base = wake_cnt;
      pulse_enter();
      cyc(2);
      chk(frozen == 1 && wake_cnt == base, "R9", frozen, 1);

      // R3 / R12 change 1 to 0, latency
      pins[0] = 0;
      wait_wake(8, lat);
      chk(lat == 3, "R12", lat, 3);
      cyc(1);
      // R7
      chk(wake == 0 && frozen == 0, "R7", {wake, frozen}, 0);
      chk(hold == 0 && hiz == 0, "R11", hold, 0);

      // R3 change 0 to 1
      pulse_enter();
      pins[0] = 1;
      wait_wake(8, lat);
      chk(lat == 3, "R3", lat, 3);

      // R4 OR of change pins
      set_mode(1, 2'b01);
      cyc(1);
      pulse_enter();
      pins[1] = 0;
      wait_wake(8, lat);
      chk(lat == 3, "R4", lat, 3);

      // R5 signature AND
      mode = '0; set_mode(1, 2'b10); set_mode(2, 2'b11);
      pins[1] = 0; pins[2] = 1;
      cyc(3);
      pulse_enter();
      pins[1] = 1;
      wait_wake(8, lat);
      chk(lat == -1 && frozen == 1, "R5", lat, -1);
      pins[2] = 0;
      wait_wake(8, lat);
      chk(lat == 3, "R5", lat, 3);

      // R8 level-sensitive re-wake
      cyc(1);
      pulse_enter();
      wait_wake(8, lat);
      chk(lat == 1, "R8", lat, 1);

      // R6 empty signature
      mode = '0; pins[1] = 0;
      cyc(3);
      pulse_enter();
      wait_wake(8, lat);
      chk(lat == -1 && frozen == 1, "R6", lat, -1);
      set_mode(0, 2'b01);
      cyc(2);
      chk(wake_cnt >= 0 && frozen == 1, "R6", frozen, 1);
      pins[0] = ~pins[0];
      wait_wake(8, lat);
      chk(lat == 3, "R6", lat, 3);

      // R10 off and incapable pins ignored
      mode = '0; set_mode(0, 2'b01); set_mode(4, 2'b01);
      keep = 6'b010000;
      cyc(1);
      pulse_enter();
      chk(hold[4] == 1, "R11", hold[4], 1);
      pins[4] = ~pins[4]; pins[3] = ~pins[3];
      wait_wake(8, lat);
      chk(lat == -1 && frozen == 1, "R10", lat, -1);
      pins[0] = ~pins[0];
      wait_wake(8, lat);
      chk(lat == 3, "R10", lat, 3);

      // concurrent change and signature: single pulse (R7)
      mode = '0; set_mode(0, 2'b01); set_mode(1, 2'b10); set_mode(2, 2'b11);
      pins[1] = 0; pins[2] = 0;
      cyc(3);
      pulse_enter();
      base = wake_cnt;
      pins[0] = ~pins[0]; pins[1] = 1;
      wait_wake(8, lat);
      chk(lat == 3, "R7", lat, 3);
      cyc(5);
      chk(wake_cnt - base == 1, "R7", wake_cnt - base, 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule